// File: doc/BRIEF.md
# Multi-Issue Instruction Dispatch Queue

This block sits between the instruction-fetch path and three execution pipes: branch, integer and floating point. It holds up to eight fixed-length 32-bit instructions. A fetch group of up to eight words arrives in one cycle, with a per-lane valid mask and a two-bit unit class per lane. The block takes the whole group only when enough slots are free. Otherwise it holds the whole group back with a single ready line.

In each cycle the block looks at the four oldest entries. It offers to each pipe the oldest instruction of that pipe's class, so up to three instructions can leave in one cycle. A pipe takes its instruction when its own ready line is high. A taken instruction leaves the queue at that edge. The entries that remain close up toward the bottom and keep their order, and the accepted fetch words land above them.

A flush input empties the queue at the next edge. During the flush cycle the block offers nothing to the pipes and takes no fetch group.

Top module: `iq_dispatch`

## Requirements
- R1: After reset the queue is empty, all three pipe valid outputs are low, and `fetch_ready` is high.
- R2: `fetch_ready` is high exactly when `flush` is low and the number of free slots (8 minus occupancy) is at least the number of set bits in `fetch_valid`. When it is low, no lane of the group enters the queue.
- R3: When a group is accepted, its valid lanes enter in lane order (lane 0 oldest) and invalid lanes are skipped. Lane i uses bits [32i+31:32i] of `fetch_data` and bits [2i+1:2i] of `fetch_cls`.
- R4: Only the four oldest entries can be offered. An instruction in position 4 or above is never offered, even when its pipe is ready.
- R5: Class code 00 and code 11 go to the integer pipe, 01 to the floating-point pipe and 10 to the branch pipe. Each pipe is offered the oldest instruction of its class in the window. A pipe's valid output does not depend on its ready input.
- R6: An instruction leaves only in a cycle where its pipe's valid and ready are both high. While it is offered and not taken, it stays offered unchanged.
- R7: Within the integer class and within the floating-point class, instructions leave in program order. A younger instruction of a class never goes while an older one of that class is blocked.
- R8: Up to three instructions, one per pipe, can leave in one cycle. A branch may be offered and leave ahead of older integer or floating-point entries.
- R9: At the edge, the entries that were not taken close up toward the bottom in their original order, and the accepted words are placed above them.
- R10: While `flush` is high, all pipe valid outputs and `fetch_ready` are low. The queue is empty after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the queue at the next edge |
| fetch_valid | input | 8 | Per-lane valid mask of the fetch group |
| fetch_data | input | 256 | Eight instruction words, lane 0 in the low bits |
| fetch_cls | input | 16 | Two-bit unit class per lane |
| fetch_ready | output | 1 | Whole fetch group is taken this cycle |
| br_valid | output | 1 | Branch instruction offered |
| br_ready | input | 1 | Branch pipe takes the offer |
| br_instr | output | 32 | Offered branch instruction |
| int_valid | output | 1 | Integer instruction offered |
| int_ready | input | 1 | Integer pipe takes the offer |
| int_instr | output | 32 | Offered integer instruction |
| fp_valid | output | 1 | Floating-point instruction offered |
| fp_ready | input | 1 | Floating-point pipe takes the offer |
| fp_instr | output | 32 | Offered floating-point instruction |

## Verification
The bench places a branch in the fifth slot behind four integer entries. A design whose window is too wide would offer that branch at once. The bench fills the queue to exactly eight and then offers a one-word group, so a wrong free-slot comparison would take a word into a full queue. A sparse valid mask that mixes in class 11 tests lane skipping. If the design compacted the lanes badly or routed class 11 wrongly, the wrong words would appear on the integer pipe. The bench also holds back an older integer behind a ready floating-point pipe, and it flushes while every pipe is ready. A design that let a younger entry of the same class pass, or that dispatched during a flush, would show a different instruction or a stray valid against the cycle-by-cycle reference model.

// File: rtl/iq_pkg.sv
package iq_pkg;

   typedef enum logic [1:0] {
      CLS_INT = 2'd0,
      CLS_FP  = 2'd1,
      CLS_BR  = 2'd2,
      CLS_ALT = 2'd3
   } iq_cls_e;

   localparam int NUM_UNITS = 3;
   localparam int U_BR  = 0;
   localparam int U_INT = 1;
   localparam int U_FP  = 2;

   // unit index that serves a class code; the spare code goes to integer
   function automatic logic [1:0] cls_to_unit(input logic [1:0] c);
      logic [1:0] u;
      case (iq_cls_e'(c))
         CLS_BR:  u = 2'(U_BR);
         CLS_FP:  u = 2'(U_FP);
         default: u = 2'(U_INT);
      endcase
      return u;
   endfunction

endpackage

// File: rtl/iq_window_pick.sv
module iq_window_pick
   import iq_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int WIN   = 4,
   localparam int CNTW = $clog2(DEPTH + 1),
   localparam int IDXW = $clog2(DEPTH)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           cls   [DEPTH],
   input  logic [CNTW-1:0]      count,
   output logic [NUM_UNITS-1:0] hit,
   output logic [IDXW-1:0]      idx   [NUM_UNITS]
);

   if (WIN < 1 || WIN > DEPTH) begin : g_bad_win
      $error("iq_window_pick: WIN must lie in 1..DEPTH");
   end

   for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
      logic            h;
      logic [IDXW-1:0] ix;

      // scan from the top of the window down so the oldest match wins
      always_comb begin
         h  = 1'b0;
         ix = '0;
         for (int j = WIN - 1; j >= 0; j--) begin
            if (j < int'(count) && cls_to_unit(cls[j]) == 2'(u)) begin
               h  = 1'b1;
               ix = IDXW'(j);
            end
         end
      end

      assign hit[u] = h;
      assign idx[u] = ix;

      // R4
      pick_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
         hit[u] |-> (int'(idx[u]) < WIN && int'(idx[u]) < int'(count)))
         else $error("pick outside window");

      // R5
      pick_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
         hit[u] |-> (cls_to_unit(cls[idx[u]]) == 2'(u)))
         else $error("pick of wrong class");
   end

endmodule

// File: rtl/iq_pack.sv
module iq_pack #(
   parameter int IW      = 32,
   parameter int DEPTH   = 8,
   parameter int FETCH_W = 8,
   localparam int CNTW   = $clog2(DEPTH + 1)
) (
   input  logic [IW-1:0]        q_word [DEPTH],
   input  logic [1:0]           q_cls  [DEPTH],
   input  logic [CNTW-1:0]      count,
   input  logic [DEPTH-1:0]     drop,
   input  logic                 app_en,
   input  logic [FETCH_W-1:0]   f_valid,
   input  logic [FETCH_W*IW-1:0] f_data,
   input  logic [FETCH_W*2-1:0] f_cls,
   output logic [IW-1:0]        n_word [DEPTH],
   output logic [1:0]           n_cls  [DEPTH],
   output logic [CNTW-1:0]      n_count
);

   if (FETCH_W < 1 || FETCH_W > DEPTH) begin : g_bad_fw
      $error("iq_pack: FETCH_W must lie in 1..DEPTH");
   end

   always_comb begin
      int k;
      k = 0;
      for (int i = 0; i < DEPTH; i++) begin
         n_word[i] = '0;
         n_cls[i]  = '0;
      end
      // survivors slide down, keeping order
      for (int j = 0; j < DEPTH; j++) begin
         if (j < int'(count) && !drop[j] && k < DEPTH) begin
            n_word[k] = q_word[j];
            n_cls[k]  = q_cls[j];
            k++;
         end
      end
      // accepted lanes stack above, lane 0 first
      for (int f = 0; f < FETCH_W; f++) begin
         if (app_en && f_valid[f] && k < DEPTH) begin
            n_word[k] = f_data[f*IW +: IW];
            n_cls[k]  = f_cls[f*2 +: 2];
            k++;
         end
      end
      n_count = CNTW'(k);
   end

endmodule

// File: rtl/iq_dispatch.sv
module iq_dispatch
   import iq_pkg::*;
#(
   parameter int IW      = 32,
   parameter int DEPTH   = 8,
   parameter int FETCH_W = 8,
   parameter int WIN     = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   flush,
   input  logic [FETCH_W-1:0]     fetch_valid,
   input  logic [FETCH_W*IW-1:0]  fetch_data,
   input  logic [FETCH_W*2-1:0]   fetch_cls,
   output logic                   fetch_ready,
   output logic                   br_valid,
   input  logic                   br_ready,
   output logic [IW-1:0]          br_instr,
   output logic                   int_valid,
   input  logic                   int_ready,
   output logic [IW-1:0]          int_instr,
   output logic                   fp_valid,
   input  logic                   fp_ready,
   output logic [IW-1:0]          fp_instr
);

   localparam int CNTW = $clog2(DEPTH + 1);
   localparam int IDXW = $clog2(DEPTH);

   if (IW < 1) begin : g_bad_iw
      $error("iq_dispatch: IW must be positive");
   end
   if (WIN > DEPTH || FETCH_W > DEPTH) begin : g_bad_shape
      $error("iq_dispatch: WIN and FETCH_W may not exceed DEPTH");
   end

   logic [IW-1:0]        q_word [DEPTH];
   logic [1:0]           q_cls  [DEPTH];
   logic [CNTW-1:0]      count;

   logic [NUM_UNITS-1:0] hit;
   logic [IDXW-1:0]      idx    [NUM_UNITS];
   logic [NUM_UNITS-1:0] u_ready;
   logic [NUM_UNITS-1:0] u_valid;
   logic [NUM_UNITS-1:0] fire;
   logic [IW-1:0]        u_instr [NUM_UNITS];
   logic [DEPTH-1:0]     drop;

   logic [IW-1:0]        n_word [DEPTH];
   logic [1:0]           n_cls  [DEPTH];
   logic [CNTW-1:0]      n_count;
   int                   fetch_need;

   iq_window_pick #(.DEPTH(DEPTH), .WIN(WIN)) pick_i (
      .clk   (clk),
      .rst_n (rst_n),
      .cls   (q_cls),
      .count (count),
      .hit   (hit),
      .idx   (idx)
   );

   assign u_ready[U_BR]  = br_ready;
   assign u_ready[U_INT] = int_ready;
   assign u_ready[U_FP]  = fp_ready;

   for (genvar u = 0; u < NUM_UNITS; u++) begin : g_port
      assign u_valid[u] = hit[u] && !flush;
      assign u_instr[u] = q_word[idx[u]];
      assign fire[u]    = u_valid[u] && u_ready[u];

      // R6
      hold_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (u_valid[u] && !u_ready[u]) |=> (flush || (u_valid[u] && $stable(u_instr[u]))))
         else $error("offer changed while stalled");
   end

   assign br_valid  = u_valid[U_BR];
   assign br_instr  = u_instr[U_BR];
   assign int_valid = u_valid[U_INT];
   assign int_instr = u_instr[U_INT];
   assign fp_valid  = u_valid[U_FP];
   assign fp_instr  = u_instr[U_FP];

   always_comb begin
      drop = '0;
      for (int u = 0; u < NUM_UNITS; u++) begin
         if (fire[u]) drop[idx[u]] = 1'b1;
      end
   end

   assign fetch_need  = $countones(fetch_valid);
   assign fetch_ready = !flush && ((DEPTH - int'(count)) >= fetch_need);

   iq_pack #(.IW(IW), .DEPTH(DEPTH), .FETCH_W(FETCH_W)) pack_i (
      .q_word  (q_word),
      .q_cls   (q_cls),
      .count   (count),
      .drop    (drop),
      .app_en  (fetch_ready),
      .f_valid (fetch_valid),
      .f_data  (fetch_data),
      .f_cls   (fetch_cls),
      .n_word  (n_word),
      .n_cls   (n_cls),
      .n_count (n_count)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            q_word[i] <= '0;
            q_cls[i]  <= '0;
         end
      end else if (flush) begin
         count <= '0;
      end else begin
         count <= n_count;
         for (int i = 0; i < DEPTH; i++) begin
            q_word[i] <= n_word[i];
            q_cls[i]  <= n_cls[i];
         end
      end
   end

   // R10
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (count == '0))
      else $error("queue not empty after flush");

   // R2
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(count) <= DEPTH)
      else $error("occupancy above depth");

   // R9
   occupancy_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flush |=> int'(count) == int'($past(count)) - $countones($past(fire))
                 + ($past(fetch_ready) ? $countones($past(fetch_valid)) : 0))
      else $error("occupancy bookkeeping broken");

   // R8
   one_per_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(drop) == $countones(fire))
      else $error("two pipes took the same slot");

endmodule

// File: tb/iq_dispatch_tb.sv
module iq_dispatch_tb_top;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         fl = 1'b0;
   logic [7:0]   fv = '0;
   logic [255:0] fd = '0;
   logic [15:0]  fc = '0;
   logic [2:0]   rdy = '0;   // [0] branch, [1] integer, [2] float

   logic         fetch_ready;
   logic         br_valid, int_valid, fp_valid;
   logic [31:0]  br_instr, int_instr, fp_instr;

   int checks = 0;
   int failures = 0;
   int gid = 0;
   int gbase = 0;

   // reference state
   logic [31:0] mw [8];
   logic [1:0]  mc [8];
   int          mcnt = 0;
   logic [2:0]  ev;
   int          ei [3];
   logic        efr;

   always #4 clk = ~clk;

   iq_dispatch dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .flush       (fl),
      .fetch_valid (fv),
      .fetch_data  (fd),
      .fetch_cls   (fc),
      .fetch_ready (fetch_ready),
      .br_valid    (br_valid),
      .br_ready    (rdy[0]),
      .br_instr    (br_instr),
      .int_valid   (int_valid),
      .int_ready   (rdy[1]),
      .int_instr   (int_instr),
      .fp_valid    (fp_valid),
      .fp_ready    (rdy[2]),
      .fp_instr    (fp_instr)
   );

   function automatic int unit_of(input logic [1:0] c);
      if (c == 2'd2) return 0;
      if (c == 2'd1) return 2;
      return 1;
   endfunction

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] dut_instr(input int u);
      if (u == 0) return br_instr;
      if (u == 1) return int_instr;
      return fp_instr;
   endfunction

   // drive one cycle of inputs, then compare against the reference
   task automatic drive(input logic [7:0] v, input logic [15:0] c, input logic [2:0] r,
                        input logic f, input string tag);
      int lim;
      @(negedge clk);
      fv = v; fc = c; rdy = r; fl = f;
      for (int i = 0; i < 8; i++) fd[32*i +: 32] = 32'(gid * 16 + i);
      gbase = gid * 16;
      gid++;
      #1;
      lim = (mcnt < 4) ? mcnt : 4;
      for (int u = 0; u < 3; u++) begin
         ev[u] = 1'b0;
         ei[u] = 0;
         for (int j = lim - 1; j >= 0; j--) begin
            if (unit_of(mc[j]) == u) begin ev[u] = 1'b1; ei[u] = j; end
         end
         if (f) ev[u] = 1'b0;
      end
      efr = !f && ((8 - mcnt) >= $countones(v));
      chk("R2", "fetch_ready", 32'(fetch_ready), 32'(efr));
      chk(tag, "valids", 32'({fp_valid, int_valid, br_valid}), 32'(ev));
      for (int u = 0; u < 3; u++) begin
         if (ev[u]) chk(tag, "instr", dut_instr(u), mw[ei[u]]);
      end
   endtask

   // advance the reference across the clock edge
   task automatic tick();
      logic [31:0] nw [8];
      logic [1:0]  nc [8];
      int k;
      logic gone;
      k = 0;
      for (int i = 0; i < 8; i++) begin nw[i] = '0; nc[i] = '0; end
      if (!fl) begin
         for (int j = 0; j < mcnt; j++) begin
            gone = 1'b0;
            for (int u = 0; u < 3; u++) if (ev[u] && rdy[u] && ei[u] == j) gone = 1'b1;
            if (!gone) begin nw[k] = mw[j]; nc[k] = mc[j]; k++; end
         end
         if (efr) begin
            for (int i = 0; i < 8; i++) begin
               if (fv[i]) begin nw[k] = fd[32*i +: 32]; nc[k] = fc[2*i +: 2]; k++; end
            end
         end
      end
      @(posedge clk);
      for (int i = 0; i < 8; i++) begin mw[i] = nw[i]; mc[i] = nc[i]; end
      mcnt = k;
   endtask

   task automatic finish_run();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 8; i++) begin mw[i] = '0; mc[i] = '0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      drive(8'h00, 16'h0, 3'b111, 1'b0, "R1");
      chk("R1", "empty valids", 32'({fp_valid, int_valid, br_valid}), 32'd0);
      chk("R1", "fetch_ready", 32'(fetch_ready), 32'd1);
      tick();

      // R3: sparse mask, lanes 0,2,5,7; lane 7 carries class 11 (integer)
      drive(8'hA5, 16'hC000, 3'b000, 1'b0, "R3");
      tick();
      begin
         int g;
         int exp_lane [4];
         g = gbase;
         exp_lane = '{0, 2, 5, 7};
         for (int s = 0; s < 4; s++) begin
            drive(8'h00, 16'h0, 3'b010, 1'b0, "R3");
            chk("R3", "int lane order", int_instr, 32'(g + exp_lane[s]));
            chk("R5", "int valid", 32'(int_valid), 32'd1);
            tick();
         end
      end

      // R4: branch in slot 4 behind four integers
      drive(8'h1F, 16'h0200, 3'b000, 1'b0, "R4");
      tick();
      begin
         int g;
         g = gbase - 16;
         drive(8'h00, 16'h0, 3'b000, 1'b0, "R4");
         chk("R4", "branch beyond window", 32'(br_valid), 32'd0);
         chk("R6", "int offered", int_instr, 32'(g + 16));
         tick();
         drive(8'h00, 16'h0, 3'b010, 1'b0, "R4");
         tick();
         drive(8'h00, 16'h0, 3'b000, 1'b0, "R9");
         chk("R9", "branch slid into window", 32'(br_valid), 32'd1);
         chk("R9", "branch word", br_instr, 32'(g + 16 + 4));
         tick();
      end

      // R10: flush while every pipe is ready and a group is offered
      drive(8'h03, 16'h0, 3'b111, 1'b1, "R10");
      chk("R10", "valids during flush", 32'({fp_valid, int_valid, br_valid}), 32'd0);
      chk("R10", "fetch_ready during flush", 32'(fetch_ready), 32'd0);
      tick();
      drive(8'h00, 16'h0, 3'b111, 1'b0, "R10");
      chk("R10", "empty after flush", 32'({fp_valid, int_valid, br_valid}), 32'd0);
      tick();

      // R8: int, int, fp, br with all pipes ready
      drive(8'h0F, 16'h0090, 3'b000, 1'b0, "R8");
      tick();
      begin
         int g;
         g = gbase;
         drive(8'h00, 16'h0, 3'b111, 1'b0, "R8");
         chk("R8", "three offers", 32'({fp_valid, int_valid, br_valid}), 32'd7);
         chk("R8", "branch overtakes", br_instr, 32'(g + 3));
         chk("R8", "oldest int", int_instr, 32'(g + 0));
         tick();
         drive(8'h00, 16'h0, 3'b000, 1'b0, "R7");
         chk("R7", "next int", int_instr, 32'(g + 1));
         tick();
      end

      // R7: integer blocked while floats drain
      drive(8'h00, 16'h0, 3'b000, 1'b1, "R10");
      tick();
      drive(8'h07, 16'h0014, 3'b000, 1'b0, "R7");
      tick();
      begin
         int g;
         g = gbase;
         drive(8'h00, 16'h0, 3'b100, 1'b0, "R7");
         chk("R7", "int held", int_instr, 32'(g + 0));
         chk("R7", "first fp", fp_instr, 32'(g + 1));
         tick();
         drive(8'h00, 16'h0, 3'b000, 1'b0, "R7");
         chk("R7", "second fp", fp_instr, 32'(g + 2));
         chk("R6", "int still held", int_instr, 32'(g + 0));
         tick();
      end

      // R2: two left, six more fills to eight, then a one-word group stalls
      drive(8'h3F, 16'h0, 3'b000, 1'b0, "R2");
      chk("R2", "six fit", 32'(fetch_ready), 32'd1);
      tick();
      drive(8'h01, 16'h0, 3'b000, 1'b0, "R2");
      chk("R2", "full stalls", 32'(fetch_ready), 32'd0);
      tick();
      drive(8'h00, 16'h0, 3'b000, 1'b0, "R2");
      tick();

      // R5: mixed traffic with random readiness, compared every cycle
      for (int n = 0; n < 4000; n++) begin
         logic [7:0] v;
         v = ($urandom % 3 == 0) ? 8'($urandom) : 8'h00;
         drive(v, 16'($urandom), 3'($urandom), ($urandom % 60) == 0, "R5");
         tick();
      end

      finish_run();
   end

endmodule